// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels may run next and keeps each channel's transfer state. Each channel has a 16-bit address counter, a 16-bit transfer count, an enable bit and a stop-on-terminal-count option. Requests from enabled channels are resolved into a single one-hot grant. The grant stays with its channel until the bus engine reports a completed transfer on the `done` strobe. Priority is either fixed, with channel 0 highest, or rotating. In rotating mode the channel most recently served drops to the bottom.

The granted channel's current address and count appear on `cur_addr` and `cur_cnt` for the bus engine to use. Each completed transfer moves the address up and the count down. When the count passes zero, a one-cycle terminal-count pulse is raised. If the stop option is set, that pulse also disables the channel.

Channels 2 and 3 can be coupled as a chain. Channel 3 then holds the parameters of the next block and cannot be granted. When channel 2 reaches terminal count, it reloads its address and count from channel 3. One write port loads every parameter and the two mode bits.

Top module: `dmaarb_top`

## Requirements
- R1: After reset, `gnt` is 0, every `chan_en` bit is 0, priority is fixed and the rotating pointer sits at channel 0.
- R2: `gnt` is one-hot or zero. It is given only to a channel that is enabled and requesting, and it appears the cycle after an idle cycle in which the request is seen. A request from a disabled channel is ignored.
- R3: In fixed priority mode (mode bit 0 = 0), the lowest-numbered eligible channel wins.
- R4: In rotating mode (mode bit 0 = 1), the channel after the one last served is highest. The order is circular, 0 to 3 and back to 0. The pointer moves only on a completion in rotating mode.
- R5: A grant is held, even against higher-priority requests, until `done` is seen while granted. The cycle after that, `gnt` is 0.
- R6: While granted, `cur_addr`/`cur_cnt` show that channel's address and count. Each completion adds 1 to the address and subtracts 1 from the count, both modulo 2^16. While idle, both outputs read 0.
- R7: A completion with count 0 raises `tc[ch]` for exactly one cycle, the cycle after `done`, and the count wraps to 0xFFFF. A channel loaded with count N therefore performs N+1 transfers.
- R8: With the stop bit set (control bit 1), terminal count clears the channel's enable bit. The channel stays disabled until a control write sets enable again.
- R9: With the stop bit clear, terminal count leaves the enable bit unchanged.
- R10: With chaining on (mode bit 1), an address or count write to channel 2 is also written to channel 3. Channel 3 is never granted while chaining is on.
- R11: With chaining on, terminal count on channel 2 loads channel 2's address and count from channel 3 instead of stepping them.
- R12: A write with `wr_en` high selects the channel by `wr_ch` and the register by `wr_reg`. The registers are: 0 = address, 1 = count, 2 = control (bit 0 enable, bit 1 stop), 3 = mode (bit 0 rotate, bit 1 chain, `wr_ch` ignored). A write to a register takes precedence over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Request line per channel |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel selected by a write |
| wr_reg | input | 2 | Register selected by a write |
| wr_data | input | 16 | Write data |
| done | input | 1 | Completion of the granted channel's transfer |
| gnt | output | 4 | One-hot grant |
| cur_addr | output | 16 | Address of the granted channel |
| cur_cnt | output | 16 | Count of the granted channel |
| tc | output | 4 | One-cycle terminal-count pulse per channel |
| chan_en | output | 4 | Enable bit per channel |

## Verification
The bench sweeps all fifteen request patterns in fixed mode and twice in rotating mode. A resolver that updates its pointer in fixed mode, or that rotates from the winner rather than from the next channel, shows a wrong grant somewhere in the rotation sweep.

Address and count wrap are driven across 0xFFFF. A counter that stops at zero, or that raises the pulse one transfer early, shows a wrong count or a misplaced `tc`.

The stop and no-stop paths are run back to back. A design that ties enable to terminal count unconditionally loses the no-stop channel. A design that forgets the stop leaves the stopped channel grantable.

The chain is run through several reloads, including a direct channel 3 rewrite. A design that steps channel 2 at terminal count, or that lets channel 3 win arbitration, shows the wrong address after the reload.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int NCH    = 4;
  localparam int IW     = $clog2(NCH);
  localparam int AW     = 16;
  localparam int CW     = 16;
  localparam int DW     = 16;
  localparam int CH_SRC = 2;
  localparam int CH_DST = 3;

  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTL  = 2'd2,
    REG_MODE = 2'd3
  } reg_sel_e;

  // Winner among rq, with channel 'top' at highest priority, circular order.
  function automatic logic [NCH-1:0] pick_next(input logic [NCH-1:0] rq,
                                               input logic [IW-1:0]  top);
    logic [NCH-1:0] res;
    int unsigned idx;
    res = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      idx = (int'(top) + k) % NCH;
      if (rq[idx]) begin
        res = '0;
        res[idx] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [IW-1:0] onehot_idx(input logic [NCH-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int k = 0; k < NCH; k++)
      if (oh[k]) r = IW'(k);
    return r;
  endfunction

  function automatic logic [IW-1:0] ptr_after(input logic [IW-1:0] served);
    return IW'((int'(served) + 1) % NCH);
  endfunction

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_step(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction
endpackage

// File: rtl/dmaarb_regdec.sv
module dmaarb_regdec
  import dmaarb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_ch,
  input  logic [1:0]     wr_reg,
  input  logic [1:0]     mode_bits,
  output logic [NCH-1:0] ld_addr,
  output logic [NCH-1:0] ld_cnt,
  output logic [NCH-1:0] ld_ctl,
  output logic           rotate_q,
  output logic           chain_q
);
  logic [NCH-1:0] ch_sel;
  logic           mode_wr;

  always_comb begin
    ch_sel = '0;
    ch_sel[wr_ch] = wr_en;
  end

  assign mode_wr = wr_en && (wr_reg == REG_MODE);

  always_comb begin
    ld_addr = (wr_reg == REG_ADDR) ? ch_sel : '0;
    ld_cnt  = (wr_reg == REG_CNT)  ? ch_sel : '0;
    ld_ctl  = (wr_reg == REG_CTL)  ? ch_sel : '0;
    // chaining mirrors source-channel parameter writes into the reload channel
    if (chain_q) begin
      ld_addr[CH_DST] = ld_addr[CH_DST] | ld_addr[CH_SRC];
      ld_cnt[CH_DST]  = ld_cnt[CH_DST]  | ld_cnt[CH_SRC];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rotate_q <= 1'b0;
      chain_q  <= 1'b0;
    end else if (mode_wr) begin
      rotate_q <= mode_bits[0];
      chain_q  <= mode_bits[1];
    end
  end
endmodule

// File: rtl/dmaarb_chan.sv
module dmaarb_chan
  import dmaarb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic          ld_ctl,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic          reload,
  input  logic [AW-1:0] rl_addr,
  input  logic [CW-1:0] rl_cnt,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          en_q,
  output logic          stop_q,
  output logic          tc_evt
);
  assign tc_evt = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld_addr) begin
      addr_q <= AW'(wdata);
    end else if (reload) begin
      addr_q <= rl_addr;
    end else if (step) begin
      addr_q <= addr_step(addr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_cnt) begin
      cnt_q <= CW'(wdata);
    end else if (reload) begin
      cnt_q <= rl_cnt;
    end else if (step) begin
      cnt_q <= cnt_step(cnt_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (ld_ctl) begin
      en_q   <= wdata[0];
      stop_q <= wdata[1];
    end else if (tc_evt && stop_q) begin
      en_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/dmaarb_resolver.sv
module dmaarb_resolver
  import dmaarb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_eff,
  input  logic           done,
  input  logic           rotate,
  output logic [NCH-1:0] gnt_q,
  output logic           svc_end
);
  logic [IW-1:0]  ptr_q;
  logic [IW-1:0]  gidx;
  logic [NCH-1:0] winner;
  logic           busy;

  assign busy    = (gnt_q != '0);
  assign svc_end = done && busy;
  assign gidx    = onehot_idx(gnt_q);
  assign winner  = pick_next(req_eff, rotate ? ptr_q : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
      ptr_q <= '0;
    end else if (!busy) begin
      gnt_q <= winner;
    end else if (done) begin
      gnt_q <= '0;
      if (rotate) ptr_q <= ptr_after(gidx);
    end
  end
endmodule

// File: rtl/dmaarb_top.sv
module dmaarb_top
  import dmaarb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_ch,
  input  logic [1:0]     wr_reg,
  input  logic [DW-1:0]  wr_data,
  input  logic           done,
  output logic [NCH-1:0] gnt,
  output logic [AW-1:0]  cur_addr,
  output logic [CW-1:0]  cur_cnt,
  output logic [NCH-1:0] tc,
  output logic [NCH-1:0] chan_en
);
  logic [NCH-1:0] ld_addr, ld_cnt, ld_ctl;
  logic           rotate_q, chain_q;
  logic [NCH-1:0] req_eff, step, tc_evt, stop_q, en_q, ctl_wr, blocked;
  logic [AW-1:0]  addr_q [NCH];
  logic [CW-1:0]  cnt_q  [NCH];
  logic [NCH-1:0] gnt_q;
  logic           svc_end;
  logic           reload_src;
  logic [NCH-1:0] tc_q;

  dmaarb_regdec u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_reg(wr_reg),
    .mode_bits(wr_data[1:0]), .ld_addr(ld_addr), .ld_cnt(ld_cnt), .ld_ctl(ld_ctl),
    .rotate_q(rotate_q), .chain_q(chain_q)
  );

  assign ctl_wr = ld_ctl;

  always_comb begin
    blocked = '0;
    blocked[CH_DST] = chain_q;
  end

  assign req_eff    = req & en_q & ~blocked;
  assign step       = svc_end ? gnt_q : '0;
  assign reload_src = chain_q && tc_evt[CH_SRC];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmaarb_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .ld_addr(ld_addr[i]), .ld_cnt(ld_cnt[i]), .ld_ctl(ld_ctl[i]),
      .wdata(wr_data), .step(step[i]),
      .reload((i == CH_SRC) ? reload_src : 1'b0),
      .rl_addr(addr_q[CH_DST]), .rl_cnt(cnt_q[CH_DST]),
      .addr_q(addr_q[i]), .cnt_q(cnt_q[i]), .en_q(en_q[i]),
      .stop_q(stop_q[i]), .tc_evt(tc_evt[i])
    );
  end

  dmaarb_resolver u_res (
    .clk(clk), .rst_n(rst_n), .req_eff(req_eff), .done(done),
    .rotate(rotate_q), .gnt_q(gnt_q), .svc_end(svc_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tc_q <= '0;
    else        tc_q <= tc_evt;
  end

  always_comb begin
    cur_addr = '0;
    cur_cnt  = '0;
    for (int k = 0; k < NCH; k++) begin
      if (gnt_q[k]) begin
        cur_addr = addr_q[k];
        cur_cnt  = cnt_q[k];
      end
    end
  end

  assign gnt     = gnt_q;
  assign tc      = tc_q;
  assign chan_en = en_q;
endmodule

// File: rtl/dmaarb_chk.sv
module dmaarb_chk
  import dmaarb_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] gnt,
  input logic           done,
  input logic [NCH-1:0] tc,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] req_eff,
  input logic [NCH-1:0] tc_evt,
  input logic [NCH-1:0] stop_q,
  input logic [NCH-1:0] ctl_wr,
  input logic           chain_q
);
  p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_gnt_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && $past(gnt) == '0) |-> ((gnt & $past(req_eff)) != '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !done) |=> (gnt == $past(gnt)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && done) |=> (gnt == '0));

  p_tc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc != '0) |=> (tc == '0));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_evt & stop_q & ~ctl_wr) != '0) |=>
      ((chan_en & $past(tc_evt & stop_q & ~ctl_wr)) == '0));

  p_nostop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_evt & ~stop_q & ~ctl_wr) != '0) |=>
      ((chan_en & $past(tc_evt & ~stop_q & ~ctl_wr)) ==
       ($past(chan_en) & $past(tc_evt & ~stop_q & ~ctl_wr))));

  p_dst_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && $past(gnt) == '0 && $past(chain_q)) |-> !gnt[CH_DST]);
endmodule

bind dmaarb_top dmaarb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .done(done), .tc(tc),
  .chan_en(chan_en), .req_eff(req_eff), .tc_evt(tc_evt),
  .stop_q(stop_q), .ctl_wr(ctl_wr), .chain_q(chain_q)
);

// File: tb/dmaarb_top_tb.sv
module dmaarb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [1:0]  wr_reg = '0;
  logic [15:0] wr_data = '0;
  logic        done = 1'b0;
  logic [3:0]  gnt, tc, chan_en;
  logic [15:0] cur_addr, cur_cnt;
  int nchk = 0;
  int nfail = 0;
  int ptr = 0;

  always #5 clk = ~clk;

  dmaarb_top dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_reg(wr_reg), .wr_data(wr_data), .done(done), .gnt(gnt),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .tc(tc), .chan_en(chan_en)
  );

  task automatic check(input logic ok, input string tg, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] rg, input logic [15:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_reg = rg; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // rotate-to-lowest-bit model of the priority pick
  function automatic logic [3:0] exp_pick(input logic [3:0] r, input int p);
    logic [7:0] dbl;
    logic [3:0] rot, low;
    dbl = {r, r} >> p;
    rot = dbl[3:0];
    low = rot & (~rot + 4'd1);
    dbl = {low, low} << p;
    return dbl[7:4];
  endfunction

  task automatic serve(input logic [3:0] eg, input logic full, input logic [15:0] ea,
                       input logic [15:0] ec, input logic [3:0] et, input string tg);
    @(negedge clk);
    check(gnt === eg, tg, 32'(gnt), 32'(eg));
    if (full) begin
      check(cur_addr === ea, {tg, " addr"}, 32'(cur_addr), 32'(ea));
      check(cur_cnt === ec, {tg, " cnt"}, 32'(cur_cnt), 32'(ec));
    end
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check(gnt === 4'd0, {tg, " release R5"}, 32'(gnt), 0);
    if (full) check(tc === et, {tg, " tc"}, 32'(tc), 32'(et));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(gnt === 4'd0, "R1 gnt", 32'(gnt), 0);
    check(chan_en === 4'd0, "R1 enables", 32'(chan_en), 0);
    check(tc === 4'd0 && cur_addr === 16'd0, "R1 tc/addr", 32'(tc), 0);
    rst_n = 1'b1;
    // R2 requests of disabled channels ignored
    req = 4'hF;
    repeat (3) @(negedge clk);
    check(gnt === 4'd0, "R2 disabled ignored", 32'(gnt), 0);
    req = 4'h0;
    // R12 control writes enable all, stop clear
    for (int c = 0; c < 4; c++) wr(2'(c), 2'd2, 16'h0001);
    check(chan_en === 4'hF, "R12 ctl write", 32'(chan_en), 32'hF);
    // R3 fixed priority sweep
    for (int p = 1; p < 16; p++) begin
      req = 4'(p);
      serve(exp_pick(4'(p), 0), 1'b0, 0, 0, 0, "R3 fixed");
      req = 4'h0;
    end
    // R5 hold against higher priority
    req = 4'h8;
    @(negedge clk);
    check(gnt === 4'h8, "R5 initial grant", 32'(gnt), 32'h8);
    req = 4'hF;
    repeat (3) @(negedge clk);
    check(gnt === 4'h8, "R5 hold", 32'(gnt), 32'h8);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    req = 4'h0;
    check(gnt === 4'h0, "R5 release", 32'(gnt), 0);
    // R4 rotating sweep (pointer still at channel 0)
    wr(2'd0, 2'd3, 16'h0001);
    ptr = 0;
    for (int rnd = 0; rnd < 2; rnd++) begin
      for (int p = 1; p < 16; p++) begin
        logic [3:0] e;
        e = exp_pick(4'(p), ptr);
        req = 4'(p);
        serve(e, 1'b0, 0, 0, 0, "R4 rotate");
        req = 4'h0;
        for (int k = 0; k < 4; k++) if (e[k]) ptr = (k + 1) % 4;
      end
    end
    wr(2'd0, 2'd3, 16'h0000);
    // R6 R7 R8 stop-on-tc with address wrap, channel 1
    wr(2'd1, 2'd0, 16'hFFFE);
    wr(2'd1, 2'd1, 16'd2);
    wr(2'd1, 2'd2, 16'h0003);
    req = 4'h2;
    serve(4'h2, 1'b1, 16'hFFFE, 16'd2, 4'h0, "R6 step0");
    serve(4'h2, 1'b1, 16'hFFFF, 16'd1, 4'h0, "R6 step1");
    serve(4'h2, 1'b1, 16'h0000, 16'd0, 4'h2, "R7 last");
    check(chan_en[1] === 1'b0, "R8 stop clears enable", 32'(chan_en), 32'hD);
    @(negedge clk);
    check(tc === 4'h0, "R7 single pulse", 32'(tc), 0);
    repeat (2) @(negedge clk);
    check(gnt === 4'h0, "R8 stays disabled", 32'(gnt), 0);
    req = 4'h0;
    wr(2'd1, 2'd2, 16'h0003);
    req = 4'h2;
    serve(4'h2, 1'b1, 16'h0001, 16'hFFFF, 4'h0, "R8 re-enable R7 wrap");
    req = 4'h0;
    // R9 stop clear, channel 0
    wr(2'd0, 2'd0, 16'h0040);
    wr(2'd0, 2'd1, 16'd0);
    req = 4'h1;
    serve(4'h1, 1'b1, 16'h0040, 16'd0, 4'h1, "R9 tc");
    check(chan_en[0] === 1'b1, "R9 enable kept", 32'(chan_en), 32'hF);
    serve(4'h1, 1'b1, 16'h0041, 16'hFFFF, 4'h0, "R9 continues");
    req = 4'h0;
    // R10 R11 chaining of channels 2 and 3
    wr(2'd0, 2'd3, 16'h0002);
    wr(2'd2, 2'd0, 16'h1000);
    wr(2'd2, 2'd1, 16'd0);
    req = 4'h8;
    repeat (3) @(negedge clk);
    check(gnt === 4'h0, "R10 ch3 blocked", 32'(gnt), 0);
    req = 4'h4;
    serve(4'h4, 1'b1, 16'h1000, 16'd0, 4'h4, "R11 first block");
    serve(4'h4, 1'b1, 16'h1000, 16'd0, 4'h4, "R10 copy reloaded");
    req = 4'h0;
    wr(2'd3, 2'd0, 16'h2000);
    wr(2'd3, 2'd1, 16'd1);
    req = 4'h4;
    serve(4'h4, 1'b1, 16'h1000, 16'd0, 4'h4, "R11 pre");
    serve(4'h4, 1'b1, 16'h2000, 16'd1, 4'h0, "R11 reload a");
    serve(4'h4, 1'b1, 16'h2001, 16'd0, 4'h4, "R11 reload b");
    serve(4'h4, 1'b1, 16'h2000, 16'd1, 4'h0, "R11 again");
    req = 4'h0;
    // R10 chaining off: ch3 grantable again, kept its own parameters
    wr(2'd0, 2'd3, 16'h0000);
    req = 4'h8;
    serve(4'h8, 1'b1, 16'h2000, 16'd1, 4'h0, "R10 ch3 unblocked");
    req = 4'h0;
    @(negedge clk);
    check(cur_addr === 16'd0 && cur_cnt === 16'd0, "R6 idle outputs",
          32'(cur_addr), 0);
    summary();
  end
endmodule